// File: doc/BRIEF.md
# Two-Level Level-Sensitive Interrupt Aggregator

This block collects 112 level-sensitive interrupt lines into fourteen groups of eight. Each group has four registers: a pending view, an acknowledge port, an enable mask and a live-level view. Software reaches them over a small synchronous register bus with 16-bit addresses and 8-bit data. Two summary registers report which groups hold unmasked pending work. The first summary also carries a cascade bit that says whether the second summary is non-zero. Software therefore reads one summary, descends into the groups it flags, and follows the cascade bit when that bit is set.

Each input passes through a two-flop synchroniser. A pending bit sets while its synchronised level is high and the source is unmasked, and it stays set after the input falls. Software removes it with a write-one acknowledge. A source whose line is still high when it is acknowledged sets again at once, which gives level semantics. A single registered interrupt output is high while anything in the first summary is set, and it follows the summary with a one-clock delay.

Top module: `lvl_irq_aggr`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: The summary of master m sits at 0x130 + m*0x80, giving 0x130 and 0x1B0. For group k (1..7) of master m, with base B: a read of B+k returns the pending view, a write to B+k+1 acknowledges, B+k+8 is the mask (read and write), and a read of B+k+15 returns the live levels. Writes to any other address are ignored, and reads of undecoded addresses return 0.
- R3: Input number n = ((m*7) + k - 1)*8 + bit maps to bit `bit` of group k in master m.
- R4: A pending bit sets while its synchronised input is high and its mask bit is 0. It stays set after the input returns low.
- R5: Writing a mask register replaces the whole mask: 1 masks a source and 0 enables it. A masked input never sets its pending bit. The pending view returns pending AND NOT mask, so masking hides a latched bit and unmasking shows it again.
- R6: Writing 1 to an acknowledge bit clears that pending bit. Bits written as 0 are untouched. If the input is still high and unmasked in the same cycle, the bit stays set, because setting wins over clearing.
- R7: The live-level register returns the synchronised input levels, whatever the mask or pending state.
- R8: Summary bit k (1..7) of a master is the OR of group k's pending view. Bit 0 of the last master always reads 0.
- R9: Bit 0 of master 0's summary is 1 exactly when master 1's summary is non-zero.
- R10: `irq_o` is the OR of master 0's summary, registered, so it changes one clock after the summary changes.
- R11: Read data is registered. It updates on the clock edge that samples a read request and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 112 | Raw interrupt levels |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The acknowledge write and the level-driven set can land on the same pending bit in the same clock. The bench provokes this by writing 1 to a source's acknowledge bit while that source's line is held high and unmasked. It then reads the pending view back and expects the bit still set; it expects the bit to clear only after the line has dropped. A second overlap is a mask write that hides a bit already latched. That case is judged by the pending view and `irq_o` going to 0 and then coming back when the source is unmasked.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int BLK_W       = 8;
  localparam int BLK_PER_MST = 7;
  localparam int N_MST       = 2;
  localparam int N_BLK       = BLK_PER_MST * N_MST;
  localparam int N_SRC       = N_BLK * BLK_W;
  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 8;

  localparam logic [ADDR_W-1:0] MST_BASE0  = 16'h0130;
  localparam logic [ADDR_W-1:0] MST_STRIDE = 16'h0080;

  localparam logic [ADDR_W-1:0] OFS_ROOT = 16'h0;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 16'h1;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 16'h8;
  localparam logic [ADDR_W-1:0] OFS_RT   = 16'hF;

  function automatic logic [ADDR_W-1:0] mst_base(input int m);
    return MST_BASE0 + ADDR_W'(m) * MST_STRIDE;
  endfunction
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lvl_irq_blk.sv
module lvl_irq_blk #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         clr_we_i,
  input  logic         msk_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] root_o,
  output logic [W-1:0] mask_o,
  output logic         act_o
);
  logic [W-1:0] pend_q, mask_q, clr_vec;

  assign clr_vec = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      // set beats clear: level still high re-asserts
      pend_q <= (pend_q & ~clr_vec) | (lvl_i & ~mask_q);
      if (msk_we_i) mask_q <= wdata_i;
    end
  end

  assign root_o = pend_q & ~mask_q;
  assign mask_o = mask_q;
  assign act_o  = |root_o;

  assert_masked_no_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(mask_q & ~pend_q) |=> ((pend_q & $past(mask_q & ~pend_q)) == '0));

  assert_level_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(lvl_i & ~mask_q) |=> ((pend_q & $past(lvl_i & ~mask_q)) == $past(lvl_i & ~mask_q)));

  assert_ack_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && |(wdata_i & ~lvl_i)) |=> ((pend_q & $past(wdata_i & ~lvl_i)) == '0));
endmodule

// File: rtl/lvl_irq_regif.sv
module lvl_irq_regif
  import lvl_irq_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_i,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [N_BLK-1:0][BLK_W-1:0]       root_i,
  input  logic [N_BLK-1:0][BLK_W-1:0]       mask_i,
  input  logic [N_BLK-1:0][BLK_W-1:0]       rt_i,
  input  logic [N_MST-1:0][DATA_W-1:0]      sum_i,
  output logic [N_BLK-1:0]                  clr_we_o,
  output logic [N_BLK-1:0]                  msk_we_o,
  output logic [DATA_W-1:0]                 rdata_o
);
  logic [DATA_W-1:0] rd_d, rdata_q;
  logic [ADDR_W-1:0] a;
  logic              wr, rd;
  int                idx;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    rd_d     = '0;
    clr_we_o = '0;
    msk_we_o = '0;
    a        = '0;
    idx      = 0;
    for (int m = 0; m < N_MST; m++) begin
      if (addr_i == mst_base(m)) rd_d = sum_i[m];
      for (int b = 1; b <= BLK_PER_MST; b++) begin
        a   = mst_base(m) + ADDR_W'(b);
        idx = m * BLK_PER_MST + b - 1;
        if (addr_i == a + OFS_ROOT) rd_d = root_i[idx];
        if (addr_i == a + OFS_MSK)  rd_d = mask_i[idx];
        if (addr_i == a + OFS_RT)   rd_d = rt_i[idx];
        if (wr && addr_i == a + OFS_CLR) clr_we_o[idx] = 1'b1;
        if (wr && addr_i == a + OFS_MSK) msk_we_o[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;

  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_q));

  assert_one_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({clr_we_o, msk_we_o}) <= 1);
endmodule

// File: rtl/lvl_irq_aggr.sv
module lvl_irq_aggr
  import lvl_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0]               lvl;
  logic [N_BLK-1:0][BLK_W-1:0]    root, mask, rt;
  logic [N_BLK-1:0]               act, clr_we, msk_we;
  logic [N_MST-1:0][DATA_W-1:0]   sum;
  logic                           irq_q;

  lvl_irq_sync #(.W(N_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (lvl)
  );

  for (genvar g = 0; g < N_BLK; g++) begin : g_blk
    assign rt[g] = lvl[g*BLK_W +: BLK_W];
    lvl_irq_blk #(.W(BLK_W)) u_blk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (lvl[g*BLK_W +: BLK_W]),
      .clr_we_i(clr_we[g]),
      .msk_we_i(msk_we[g]),
      .wdata_i (wdata_i),
      .root_o  (root[g]),
      .mask_o  (mask[g]),
      .act_o   (act[g])
    );
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_sum
    assign sum[m][BLK_PER_MST:1] = act[m*BLK_PER_MST +: BLK_PER_MST];
    if (m < N_MST - 1) begin : g_chain
      assign sum[m][0] = |sum[m+1];
    end else begin : g_last
      assign sum[m][0] = 1'b0;
    end
  end

  lvl_irq_regif u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .root_i  (root),
    .mask_i  (mask),
    .rt_i    (rt),
    .sum_i   (sum),
    .clr_we_o(clr_we),
    .msk_we_o(msk_we),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |sum[0];
  end

  assign irq_o = irq_q;

  assert_irq_lag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|act)));

  assert_chain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |act[N_BLK-1:BLK_PER_MST] |-> sum[0][0]);

  assert_last_bit0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sum[N_MST-1][0]);
endmodule

// File: tb/lvl_irq_aggr_tb.sv
module lvl_irq_aggr_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [111:0] src = '0;
  logic         req = 1'b0, we = 1'b0;
  logic [15:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         irq;
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  always #10 clk = ~clk;

  lvl_irq_aggr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irq", irq, 0);
    check("R1 rdata", rdata, 0);
    rd(16'h139, v); check("R1 mask m0b1", v, 8'hFF);
    rd(16'h1BF, v); check("R1 mask m1b7", v, 8'hFF);
    rd(16'h131, v); check("R1 root", v, 0);
    rd(16'h130, v); check("R8 sum0 idle", v, 0);
  endtask

  task automatic t_masked_and_rt();
    logic [7:0] v;
    src[0] = 1; src[111] = 1; settle(5);
    rd(16'h131, v); check("R5 masked no pend", v, 0);
    check("R5 irq masked", irq, 0);
    rd(16'h140, v); check("R7 rt m0b1", v, 8'h01);
    rd(16'h1C6, v); check("R7 rt m1b7 src111", v, 8'h80);
    src[111] = 0;
  endtask

  task automatic t_level_collision();
    logic [7:0] v;
    wr(16'h139, 8'hFE); settle(3);
    rd(16'h131, v); check("R4 pend set", v, 8'h01);
    rd(16'h130, v); check("R8 sum0 bit1", v, 8'h02);
    check("R10 irq high", irq, 1);
    wr(16'h132, 8'h01);
    rd(16'h131, v); check("R6 set wins over ack", v, 8'h01);
    rd(16'h149, v); check("R2 undecoded read", v, 0);
    src[0] = 0; settle(4);
    rd(16'h131, v); check("R4 latched after fall", v, 8'h01);
    wr(16'h132, 8'h01); settle(2);
    rd(16'h131, v); check("R6 ack clears", v, 0);
    check("R10 irq low", irq, 0);
  endtask

  task automatic t_partial_ack();
    logic [7:0] v;
    wr(16'h139, 8'hF6);
    src[3] = 1; settle(2); src[0] = 1; settle(4); src[0] = 0; src[3] = 0; settle(4);
    rd(16'h131, v); check("R4 two latched", v, 8'h09);
    wr(16'h131, 8'hFF); wr(16'h130, 8'hFF);
    rd(16'h131, v); check("R2 write to root/summary ignored", v, 8'h09);
    wr(16'h132, 8'h08);
    rd(16'h131, v); check("R6 zero bits untouched", v, 8'h01);
    wr(16'h132, 8'h01);
    rd(16'h131, v); check("R6 second ack", v, 0);
  endtask

  task automatic t_chain();
    logic [7:0] v;
    // source 77 = ((7+3-1)*8+5): master 1, group 3, bit 5
    wr(16'h1BB, 8'hDF);
    src[77] = 1; settle(5);
    rd(16'h1B3, v); check("R3 root m1b3", v, 8'h20);
    rd(16'h1B0, v); check("R8 sum1 bit3, bit0 zero", v, 8'h08);
    rd(16'h130, v); check("R9 chain bit", v, 8'h01);
    check("R10 irq via chain", irq, 1);
    src[77] = 0; settle(4);
    wr(16'h1B4, 8'h20); settle(2);
    rd(16'h130, v); check("R9 chain clears", v, 0);
    check("R10 irq low after chain", irq, 0);
  endtask

  task automatic t_mask_hide();
    logic [7:0] v;
    // source 55: master 0, group 7, bit 7
    wr(16'h13F, 8'h7F);
    src[55] = 1; settle(4); src[55] = 0; settle(4);
    rd(16'h137, v); check("R3 root m0b7", v, 8'h80);
    wr(16'h13F, 8'hFF); settle(2);
    rd(16'h137, v); check("R5 hidden by mask", v, 0);
    check("R5 irq hidden", irq, 0);
    rd(16'h13F, v); check("R5 mask readback", v, 8'hFF);
    wr(16'h13F, 8'h7F); settle(2);
    rd(16'h130, v); check("R5 revealed sum bit7", v, 8'h80);
    check("R10 irq revealed", irq, 1);
    wr(16'h138, 8'h80); settle(2);
    rd(16'h137, v); check("R6 ack last group", v, 0);
  endtask

  task automatic t_rd_hold();
    logic [7:0] v;
    rd(16'h139, v);
    settle(3);
    check("R11 rdata holds", rdata, 8'hF6);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1;
    settle(2);
    t_reset();
    t_masked_and_rt();
    t_level_collision();
    t_partial_ack();
    t_chain();
    t_mask_hide();
    t_rd_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule